// File: doc/BRIEF.md
# Receive Packet Byte Accounting

This block keeps the byte bookkeeping for the receive path of a card-bus function. At the start of each incoming packet it latches the packet length and loads a bytes-remaining counter from it. As bytes land in the receive buffer, it raises an occupancy count and lowers the bytes-remaining counter by the same amount. Each 32-bit word that firmware pops from the buffer lowers the occupancy by four. The buffer storage itself lives elsewhere.

Firmware reads occupancy and remaining bytes as two separate register reads, and data can keep arriving between them. To keep the pair consistent, a read of occupancy takes a snapshot of the remaining-bytes count. Later reads of the remaining-bytes register return that snapshot, with a lock flag in bit 15. The remaining-bytes read strobe then releases the lock. Firmware is expected to read occupancy first and remaining bytes second.

Top module: `rx_byte_acct`

## Requirements
- R1: After a synchronous reset, the packet length, occupancy, remaining-bytes word and lock flag are all zero.
- R2: A packet-start strobe loads `pkt_len` into the packet-length output and into the remaining-bytes counter. Any bytes arriving in the same cycle are subtracted from the new length, with a floor at zero.
- R3: Each cycle, `arr_bytes` is added to the occupancy and subtracted from the remaining-bytes counter.
- R4: A firmware pop lowers the occupancy by 4, with a floor at zero, and leaves the remaining-bytes counter unchanged.
- R5: The occupancy saturates at its maximum of 2047 and does not wrap.
- R6: An occupancy read strobe sets the lock and captures the remaining-bytes value shown in that cycle. While the lock is set, bits 10:0 of `left_word_o` hold that snapshot and bit 15 reads 1, even as the live count moves.
- R7: A remaining-bytes read strobe while locked clears the lock from the next cycle on. If an occupancy read occurs in the same cycle, the occupancy read wins and the lock is set again with a fresh snapshot.
- R8: While unlocked, bits 10:0 of `left_word_o` show the live counter, and bits 15:11 are zero.
- R9: A flush zeroes the occupancy and clears the lock. It overrides any arrival or pop in the same cycle, and leaves the packet length and the remaining-bytes counter untouched.
- R10: A packet-start strobe clears the lock. It takes precedence over an occupancy read in the same cycle.
- R11: The remaining-bytes counter stops at zero and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Start of a new received packet |
| pkt_len | input | 10 | Length of the packet that is starting, in bytes |
| arr_bytes | input | 3 | Bytes written into the receive buffer this cycle |
| fw_pop | input | 1 | Firmware pops one 32-bit word from the buffer |
| rd_occ | input | 1 | Read strobe of the occupancy register |
| rd_left | input | 1 | Read strobe of the remaining-bytes register |
| flush | input | 1 | Receive buffer flush |
| pkt_len_o | output | 10 | Latched packet length |
| occ_o | output | 11 | Bytes currently in the receive buffer |
| left_word_o | output | 16 | Remaining bytes in bits 10:0, lock flag in bit 15 |

## Verification
A wrong internal state appears at the ports in the cycle after the edge that caused it. An arithmetic slip in occupancy or the remaining-bytes counter shows directly in `occ_o` or in `left_word_o`. A snapshot taken one cycle late, or from the post-update value, only shows as a value that is off by one arrival, so reads are placed alongside arrivals. A lock that fails to set or clear flips bit 15 and usually the low field at the next sample, so read strobes are mixed with flushes and packet starts. Saturation errors stay hidden until the counters reach their bounds, so directed runs fill occupancy past 2047 and drain the remaining-bytes counter past zero.

// File: rtl/rx_acct_pkg.sv
package rx_acct_pkg;
  // Width of the readable remaining-bytes word and position of the lock flag
  localparam int WORD_W   = 16;
  localparam int LOCK_POS = 15;
endpackage

// File: rtl/rx_left_ctr.sv
module rx_left_ctr #(
  parameter int LEN_W = 10,
  parameter int CNT_W = 11,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_start,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [INC_W-1:0] arr_bytes,
  output logic [LEN_W-1:0] len_q,
  output logic [CNT_W-1:0] left_q
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] base;
  logic [EXT_W-1:0] amt;
  logic [EXT_W-1:0] left_nxt;

  always_comb begin
    base = pkt_start ? EXT_W'(pkt_len) : EXT_W'(left_q);
    amt  = EXT_W'(arr_bytes);
    left_nxt = (base > amt) ? (base - amt) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= '0;
      left_q <= '0;
    end else begin
      if (pkt_start) len_q <= pkt_len;
      left_q <= left_nxt[CNT_W-1:0];
    end
  end

  // R2
  load_len_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_start && arr_bytes == '0) |=> (left_q == CNT_W'($past(pkt_len)) && len_q == $past(pkt_len)));
  // R11
  no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !pkt_start |=> (left_q <= $past(left_q)));
endmodule

// File: rtl/rx_occ_ctr.sv
module rx_occ_ctr #(
  parameter int CNT_W      = 11,
  parameter int INC_W      = 3,
  parameter int WORD_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INC_W-1:0] arr_bytes,
  input  logic             fw_pop,
  input  logic             flush,
  output logic [CNT_W-1:0] occ_q
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] MAXV = SUM_W'((1 << CNT_W) - 1);

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] take;
  logic [SUM_W-1:0] rem;

  always_comb begin
    sum  = SUM_W'(occ_q) + SUM_W'(arr_bytes);
    take = fw_pop ? SUM_W'(WORD_BYTES) : '0;
    rem  = (sum > take) ? (sum - take) : '0;
    if (rem > MAXV) rem = MAXV;
  end

  always_ff @(posedge clk) begin
    if (rst)        occ_q <= '0;
    else if (flush) occ_q <= '0;
    else            occ_q <= rem[CNT_W-1:0];
  end

  // R9
  flush_zero_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (occ_q == '0));
  // R4
  pop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fw_pop && !flush && arr_bytes == '0 && occ_q >= CNT_W'(WORD_BYTES))
      |=> (occ_q == $past(occ_q) - CNT_W'(WORD_BYTES)));
endmodule

// File: rtl/rx_left_snap.sv
module rx_left_snap
  import rx_acct_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  left_live,
  input  logic              rd_occ,
  input  logic              rd_left,
  input  logic              flush,
  input  logic              pkt_start,
  output logic [WORD_W-1:0] left_word
);
  localparam int PAD_W = LOCK_POS - CNT_W;

  logic             lock_q;
  logic [CNT_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      snap_q <= '0;
    end else if (flush || pkt_start) begin
      lock_q <= 1'b0;
    end else if (rd_occ) begin
      lock_q <= 1'b1;
      snap_q <= left_live;
    end else if (rd_left) begin
      lock_q <= 1'b0;
    end
  end

  always_comb begin
    left_word = {lock_q, {PAD_W{1'b0}}, (lock_q ? snap_q : left_live)};
  end

  // R6
  snap_take_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_occ && !flush && !pkt_start) |=> (lock_q && snap_q == $past(left_live)));
  // R10
  lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (flush || pkt_start) |=> !left_word[LOCK_POS]);
  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_left && !rd_occ) |=> !lock_q);
endmodule

// File: rtl/rx_byte_acct.sv
module rx_byte_acct
  import rx_acct_pkg::*;
#(
  parameter int LEN_W      = 10,
  parameter int CNT_W      = 11,
  parameter int INC_W      = 3,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_start,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [INC_W-1:0]  arr_bytes,
  input  logic              fw_pop,
  input  logic              rd_occ,
  input  logic              rd_left,
  input  logic              flush,
  output logic [LEN_W-1:0]  pkt_len_o,
  output logic [CNT_W-1:0]  occ_o,
  output logic [WORD_W-1:0] left_word_o
);
  logic [CNT_W-1:0] left_live;

  rx_left_ctr #(.LEN_W(LEN_W), .CNT_W(CNT_W), .INC_W(INC_W)) u_left (
    .clk(clk), .rst(rst), .pkt_start(pkt_start), .pkt_len(pkt_len),
    .arr_bytes(arr_bytes), .len_q(pkt_len_o), .left_q(left_live)
  );

  rx_occ_ctr #(.CNT_W(CNT_W), .INC_W(INC_W), .WORD_BYTES(WORD_BYTES)) u_occ (
    .clk(clk), .rst(rst), .arr_bytes(arr_bytes), .fw_pop(fw_pop),
    .flush(flush), .occ_q(occ_o)
  );

  rx_left_snap #(.CNT_W(CNT_W)) u_snap (
    .clk(clk), .rst(rst), .left_live(left_live), .rd_occ(rd_occ),
    .rd_left(rd_left), .flush(flush), .pkt_start(pkt_start),
    .left_word(left_word_o)
  );

  // R1
  init_zero_chk: assert property (@(posedge clk)
    $past(rst) |-> (occ_o == '0 && left_word_o == '0 && pkt_len_o == '0));
endmodule

// File: tb/rx_byte_acct_bench.sv
module rx_byte_acct_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pkt_start = 1'b0;
  logic [9:0]  pkt_len = '0;
  logic [2:0]  arr_bytes = '0;
  logic        fw_pop = 1'b0, rd_occ = 1'b0, rd_left = 1'b0, flush = 1'b0;
  logic [9:0]  pkt_len_o;
  logic [10:0] occ_o;
  logic [15:0] left_word_o;

  int checks = 0, errors = 0;
  int m_len = 0, m_occ = 0, m_left = 0, m_snap = 0;
  bit m_lock = 0;

  always #(CLK_P/2) clk = ~clk;

  rx_byte_acct u_rx_byte_acct (
    .clk(clk), .rst(rst), .pkt_start(pkt_start), .pkt_len(pkt_len),
    .arr_bytes(arr_bytes), .fw_pop(fw_pop), .rd_occ(rd_occ), .rd_left(rd_left),
    .flush(flush), .pkt_len_o(pkt_len_o), .occ_o(occ_o), .left_word_o(left_word_o)
  );

  function automatic int floor_sub(int a, int b);
    return (a > b) ? a - b : 0;
  endfunction

  function automatic int exp_word();
    return (m_lock ? m_snap : m_left) | (int'(m_lock) << 15);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "pkt_len", int'(pkt_len_o), m_len);
    chk(tag, "occupancy", int'(occ_o), m_occ);
    chk(tag, "left_word", int'(left_word_o), exp_word());
  endtask

  // One cycle: drive at the falling edge, update the model, sample at the next falling edge
  task automatic cyc(bit ps, int len, int ab, bit pop, bit ro, bit rl, bit fl, string tag);
    int nocc;
    pkt_start = ps; pkt_len = 10'(len); arr_bytes = 3'(ab);
    fw_pop = pop; rd_occ = ro; rd_left = rl; flush = fl;
    if (fl || ps) m_lock = 0;
    else if (ro) begin m_lock = 1; m_snap = m_left; end
    else if (rl) m_lock = 0;
    if (ps) m_len = len;
    m_left = ps ? floor_sub(len, ab) : floor_sub(m_left, ab);
    nocc = m_occ + ab - (pop ? 4 : 0);
    if (nocc < 0) nocc = 0;
    if (nocc > 2047) nocc = 2047;
    m_occ = fl ? 0 : nocc;
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1");
    cyc(1, 100, 0, 0, 0, 0, 0, "R2");
    repeat (3) cyc(0, 0, 4, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 1, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 1, 0, 0, "R6");
    cyc(0, 0, 4, 0, 0, 0, 0, "R6");
    cyc(0, 0, 3, 0, 1, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 1, 0, "R7");
    cyc(0, 0, 1, 0, 0, 0, 0, "R8");
    cyc(0, 0, 2, 0, 1, 1, 0, "R7");
    cyc(1, 3, 4, 0, 1, 0, 0, "R10");
    cyc(0, 0, 4, 0, 0, 0, 0, "R11");
    cyc(1, 500, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 1, 0, 0, "R6");
    cyc(0, 0, 4, 1, 0, 0, 1, "R9");
    cyc(0, 0, 0, 1, 0, 0, 0, "R4");
    cyc(1, 1023, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 520; i++) cyc(0, 0, 4, 0, 0, 0, 0, "R5");
    cyc(0, 0, 7, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, 0, 1, "R9");
    for (int i = 0; i < 4000; i++) begin
      bit ps = ($urandom_range(0, 39) == 0);
      bit fl = ($urandom_range(0, 59) == 0);
      cyc(ps, int'($urandom_range(0, 1023)), int'($urandom_range(0, 5) > 4 ? 7 : $urandom_range(0, 4)),
          ($urandom_range(0, 2) == 0), ($urandom_range(0, 7) == 0), ($urandom_range(0, 5) == 0),
          fl, "R3 R4 R6 R7 mixed");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule